// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Qualification

This block compares a reference pulse train against a divided-down oscillator pulse train, both sampled on a fast system clock. A rising edge on the reference raises the `up_o` command. A rising edge on the divided input raises the `dn_o` command. Once both commands are high, both are cleared after a short fixed delay. Because each comparison always ends with a short overlap of the two commands, the charge pump sees no dead zone around zero phase error.

Each comparison produces a phase error, measured in system clock cycles. The loop is declared locked after a programmable run of consecutive comparisons whose error stays within a threshold. Lock is dropped on the first comparison whose error is over that threshold.

Lock drives an active-low pin and a status bit. When automatic current switching is enabled, lock also forces the charge-pump current select to its low level, and a status flag reports that this is happening. A test select can route the raw reference, or a toggle at half the divided rate, to the pin in place of the lock signal.

Top module: `pfd_lock`

## Requirements
- R1: A rising edge on `ref_i` sets `up_o` at the next clock edge, and a rising edge on `div_i` sets `dn_o` at the next clock edge. When one edge lags the other by d cycles, the leading command stays high for d+RST_DLY cycles and the lagging command stays high for RST_DLY cycles.
- R2: Once `up_o` and `dn_o` are both high, both clear after exactly RST_DLY cycles. They therefore overlap for RST_DLY cycles even when the phase error is zero.
- R3: The phase error of a comparison is the number of cycles in which exactly one command is high. A comparison counts as good when this error is no larger than THRESH.
- R4: `lock_o` rises when the count of consecutive good comparisons reaches `lock_len_i`. A `lock_len_i` of 0 behaves like 1.
- R5: `lock_o` falls at the first comparison whose error exceeds THRESH, and the count of good comparisons restarts from zero.
- R6: With `tsel_i` = 0 or 3, `pin_o` is low while `lock_o` is high and high otherwise.
- R7: With `tsel_i` = 1, `pin_o` equals `ref_i`. With `tsel_i` = 2, `pin_o` carries a toggle that is 0 after reset and inverts on each rising edge of `div_i`.
- R8: `cp_hi_o` follows `cp_set_i`, except that it is 0 while both `auto_en_i` and `lock_o` are high.
- R9: `acps_o` is high exactly when both `auto_en_i` and `lock_o` are high.
- R10: After reset, `up_o`, `dn_o`, `lock_o` and `acps_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples both pulse trains |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference pulse train |
| div_i | input | 1 | Divided oscillator pulse train |
| cp_set_i | input | 1 | Programmed charge-pump current level (1 = high) |
| auto_en_i | input | 1 | Enables the automatic drop to low current on lock |
| lock_len_i | input | LEN_W | Number of consecutive good comparisons needed for lock |
| tsel_i | input | 2 | Pin source: 0/3 lock, 1 reference, 2 half divided rate |
| up_o | output | 1 | Charge-pump up command |
| dn_o | output | 1 | Charge-pump down command |
| pin_o | output | 1 | Active-low lock, or the selected test signal |
| lock_o | output | 1 | Lock status, 1 while locked |
| cp_hi_o | output | 1 | Effective current select (1 = high) |
| acps_o | output | 1 | High while the automatic switch holds the current low |

## Verification
The bench builds the block with RST_DLY=2, THRESH=2, ERR_W=8 and LEN_W=4. With these values a phase lag of two cycles sits exactly on the pass side of the threshold and a lag of three cycles sits just over it, so the test reaches both sides of the boundary in both lead directions. Run lengths of three and one bring the lock-entry count and its shortest case within reach. They also exercise the restart of the count after a lost lock.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PIN_LOCK  = 2'd0,
    PIN_REF   = 2'd1,
    PIN_HDIV  = 2'd2,
    PIN_LOCK2 = 2'd3
  } pin_sel_e;
endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int RST_DLY = 2,
  parameter int ERR_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             div_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             div_edge_o,
  output logic             eval_o,
  output logic [ERR_W-1:0] err_o
);
  localparam int DLY_W = $clog2(RST_DLY + 1);

  logic             ref_q, div_q, up_q, dn_q;
  logic [DLY_W-1:0] dly_q;
  logic [ERR_W-1:0] err_q;
  logic             ref_rise, div_rise, clr;

  assign ref_rise = ref_i & ~ref_q;
  assign div_rise = div_i & ~div_q;
  assign clr      = up_q & dn_q & (dly_q == DLY_W'(RST_DLY - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      div_q <= 1'b0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      dly_q <= '0;
      err_q <= '0;
    end else begin
      ref_q <= ref_i;
      div_q <= div_i;
      if (clr) begin
        up_q  <= 1'b0;
        dn_q  <= 1'b0;
        dly_q <= '0;
        err_q <= '0;
      end else begin
        if (ref_rise) up_q <= 1'b1;
        if (div_rise) dn_q <= 1'b1;
        if (up_q && dn_q) dly_q <= dly_q + 1'b1;
        // phase error: cycles with exactly one command active
        if ((up_q ^ dn_q) && (err_q != '1)) err_q <= err_q + 1'b1;
      end
    end
  end

  assign up_o       = up_q;
  assign dn_o       = dn_q;
  assign div_edge_o = div_rise;
  assign eval_o     = clr;
  assign err_o      = err_q;

  // R2
  no_stuck_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && dn_q) |-> (dly_q < DLY_W'(RST_DLY)));
  // R1
  up_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_i && !ref_q && !clr) |=> up_q);
endmodule

// File: rtl/lock_qual.sv
module lock_qual #(
  parameter int THRESH = 2,
  parameter int ERR_W  = 8,
  parameter int LEN_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eval_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic [LEN_W-1:0] lock_len_i,
  output logic             locked_o
);
  logic [LEN_W-1:0] good_q;
  logic             locked_q;
  logic             bad;
  logic [LEN_W:0]   good_nxt;

  assign bad      = err_i > ERR_W'(THRESH);
  assign good_nxt = {1'b0, good_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q   <= '0;
      locked_q <= 1'b0;
    end else if (eval_i) begin
      if (bad) begin
        good_q   <= '0;
        locked_q <= 1'b0;
      end else begin
        if (good_q != '1) good_q <= good_q + 1'b1;
        if (good_nxt >= {1'b0, lock_len_i}) locked_q <= 1'b1;
      end
    end
  end

  assign locked_o = locked_q;

  // R5
  unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && (err_i > ERR_W'(THRESH))) |=> !locked_o);
  // R4
  lock_at_eval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(eval_i));
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock
  import pfd_pkg::*;
#(
  parameter int RST_DLY = 2,
  parameter int THRESH  = 2,
  parameter int ERR_W   = 8,
  parameter int LEN_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             div_i,
  input  logic             cp_set_i,
  input  logic             auto_en_i,
  input  logic [LEN_W-1:0] lock_len_i,
  input  logic [1:0]       tsel_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             pin_o,
  output logic             lock_o,
  output logic             cp_hi_o,
  output logic             acps_o
);
  logic             div_edge, eval, locked, hdiv_q;
  logic [ERR_W-1:0] err;
  pin_sel_e         sel;

  pfd_core #(.RST_DLY(RST_DLY), .ERR_W(ERR_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_i      (ref_i),
    .div_i      (div_i),
    .up_o       (up_o),
    .dn_o       (dn_o),
    .div_edge_o (div_edge),
    .eval_o     (eval),
    .err_o      (err)
  );

  lock_qual #(.THRESH(THRESH), .ERR_W(ERR_W), .LEN_W(LEN_W)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eval_i     (eval),
    .err_i      (err),
    .lock_len_i (lock_len_i),
    .locked_o   (locked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hdiv_q <= 1'b0;
    else if (div_edge) hdiv_q <= ~hdiv_q;
  end

  assign sel = pin_sel_e'(tsel_i);

  always_comb begin
    unique case (sel)
      PIN_REF:  pin_o = ref_i;
      PIN_HDIV: pin_o = hdiv_q;
      default:  pin_o = ~locked;
    endcase
  end

  assign lock_o  = locked;
  assign acps_o  = auto_en_i & locked;
  assign cp_hi_o = cp_set_i & ~(auto_en_i & locked);

  // R9
  acps_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acps_o |-> !cp_hi_o);
  // R8
  manual_cp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |-> (cp_hi_o == cp_set_i));
  // R6
  lock_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tsel_i == 2'd0) && lock_o) |-> !pin_o);
endmodule

// File: tb/sim_pfd_lock.sv
module sim_pfd_lock;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  localparam int D_TAB [NV] = '{0, 1, -2, 2, 3, -1, 0, 1, -3};
  localparam bit L_TAB [NV] = '{0, 0, 1, 1, 0, 0, 0, 1, 0};

  logic clk = 0, rst_ni = 0;
  logic ref_i = 0, div_i = 0, cp_set_i = 0, auto_en_i = 0;
  logic [3:0] lock_len_i = 4'd3;
  logic [1:0] tsel_i = 2'd0;
  logic up_o, dn_o, pin_o, lock_o, cp_hi_o, acps_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_lock #(.RST_DLY(2), .THRESH(2), .ERR_W(8), .LEN_W(4)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ref_i(ref_i), .div_i(div_i),
    .cp_set_i(cp_set_i), .auto_en_i(auto_en_i), .lock_len_i(lock_len_i),
    .tsel_i(tsel_i), .up_o(up_o), .dn_o(dn_o), .pin_o(pin_o),
    .lock_o(lock_o), .cp_hi_o(cp_hi_o), .acps_o(acps_o));

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one comparison: d > 0 reference leads by d cycles, d < 0 divided leads
  task automatic compare(int d, output int upc, output int dnc, output int bothc);
    int rs = (d >= 0) ? 0 : -d;
    int ds = (d >= 0) ? d : 0;
    upc = 0; dnc = 0; bothc = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      upc   += int'(up_o);
      dnc   += int'(dn_o);
      bothc += int'(up_o & dn_o);
      ref_i = (c >= rs) && (c < rs + 6);
      div_i = (c >= ds) && (c < ds + 6);
    end
  endtask

  initial begin
    int u, dn, b, ad, p;
    repeat (3) @(negedge clk);
    check("R10 up", up_o, 0);
    check("R10 dn", dn_o, 0);
    check("R10 lock", lock_o, 0);
    check("R10 acps", acps_o, 0);
    check("R6 pin reset", pin_o, 1);
    rst_ni = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      compare(D_TAB[i], u, dn, b);
      ad = (D_TAB[i] < 0) ? -D_TAB[i] : D_TAB[i];
      check("R1 up width", u, (D_TAB[i] >= 0) ? ad + 2 : 2);
      check("R1 dn width", dn, (D_TAB[i] <= 0) ? ad + 2 : 2);
      check("R2 overlap", b, 2);
      check("R3 R4 R5 lock", lock_o, int'(L_TAB[i]));
      check("R6 pin", pin_o, int'(!L_TAB[i]));
    end

    // unlocked now
    auto_en_i = 1; cp_set_i = 1; #1;
    check("R8 unlocked auto", cp_hi_o, 1);
    check("R9 unlocked", acps_o, 0);
    repeat (3) compare(0, u, dn, b);
    check("R4 relock", lock_o, 1);
    #1;
    check("R8 locked auto", cp_hi_o, 0);
    check("R9 locked auto", acps_o, 1);
    auto_en_i = 0; #1;
    check("R8 manual hi", cp_hi_o, 1);
    check("R9 manual", acps_o, 0);
    cp_set_i = 0; #1;
    check("R8 manual lo", cp_hi_o, 0);

    lock_len_i = 4'd1;
    compare(3, u, dn, b);
    check("R5 drop", lock_o, 0);
    compare(-1, u, dn, b);
    check("R4 len1", lock_o, 1);
    lock_len_i = 4'd0;
    compare(3, u, dn, b);
    compare(2, u, dn, b);
    check("R4 len0", lock_o, 1);

    tsel_i = 2'd3; #1;
    check("R6 sel3", pin_o, 0);
    tsel_i = 2'd2; #1;
    p = int'(pin_o);
    @(negedge clk); div_i = 1;
    @(negedge clk);
    check("R7 hdiv flip", pin_o, 1 - p);
    div_i = 0;
    @(negedge clk); @(negedge clk);
    check("R7 hdiv hold", pin_o, 1 - p);
    tsel_i = 2'd1; ref_i = 1; #1;
    check("R7 ref hi", pin_o, 1);
    ref_i = 0; #1;
    check("R7 ref lo", pin_o, 0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule